// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block runs the hardware half of taking an interrupt for a small 16-bit processor core. A device raises a request. The sequencer grants the bus to that device and captures the vector address the device then drives. It fetches the handler's program counter and status word from that vector slot and pushes the interrupted program counter and status word onto a downward-growing memory stack. It then hands the core the new program counter, status word and stack pointer in one load cycle, so the first instruction fetched belongs to the handler and no software dispatcher runs first.

Vector slots must lie in a small window at the bottom of memory. Each slot is two aligned 16-bit words: the handler PC first, then the handler status word. A vector that is odd or that lies outside the window ends the sequence. In that case the block raises an error pulse, makes no memory access and does not load the core. The block serves one requester at a time. A new request is not taken until the current sequence has signalled completion.

The memory port is word wide and byte addressed. A read issued in one cycle returns its data on `mem_rdata` in the following cycle. A write completes in the cycle it is issued.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is applied, `dev_grant`, `mem_req`, `mem_we`, `core_load`, `done` and `vec_err` are all low.
- R2: When idle, a high `dev_req` raises `dev_grant` on the next cycle, and `dev_grant` stays high for as long as `dev_vec_valid` is low.
- R3: In the cycle after `dev_grant` and `dev_vec_valid` are both high, `dev_grant` is low, and the vector address, `core_pc`, `core_sw` and `core_sp` have been captured; later changes on those inputs have no effect on the sequence.
- R4: For a valid vector V, the block issues exactly two reads in consecutive cycles: first at V (new PC), then at V+2 (new status word).
- R5: After the reads, the block issues exactly two writes in consecutive cycles: the captured status word to SP-2, then the captured PC to SP-4, where SP is the captured `core_sp`.
- R6: Five cycles after the vector is captured, `core_load` and `done` are high together for exactly one cycle. In that cycle `new_pc` equals the word read at V, `new_sw` equals the word read at V+2, `new_sp` equals SP-4, and `vec_err` is low.
- R7: A vector address at or above `VEC_LIMIT` (default 0x0100) causes `vec_err` and `done` to pulse for one cycle in the cycle after capture, with no memory access and no `core_load`.
- R8: A vector address with bit 0 set is handled the same way as in R7, whatever its value.
- R9: While a sequence is in progress, `dev_req` is ignored and `dev_grant` stays low. A request held through `done` is granted two cycles after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_req | input | 1 | Device interrupt request |
| dev_grant | output | 1 | Bus grant to the requesting device |
| dev_vec_valid | input | 1 | Device is driving its vector address |
| dev_vec_addr | input | 16 | Vector address from the device |
| core_pc | input | 16 | Program counter of the interrupted code |
| core_sw | input | 16 | Status word of the interrupted code |
| core_sp | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write when high |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after the read |
| core_load | output | 1 | One-cycle strobe to load new PC, status word and SP |
| new_pc | output | 16 | Handler program counter |
| new_sw | output | 16 | Handler status word |
| new_sp | output | 16 | Stack pointer after both pushes |
| done | output | 1 | One-cycle pulse at the end of every sequence |
| vec_err | output | 1 | One-cycle pulse when a vector is rejected |

## Verification
The assertions assume a well-behaved device. It raises `dev_vec_valid` only while it holds the grant and drops it once the grant falls. The assertions also assume that memory answers every read exactly one cycle later. The bench model returns registered read data with that fixed latency. The bench drives the vector only in a granted cycle and keeps `core_sp` even and clear of the vector window. Under these conditions the rule that stack writes are word aligned follows from the stimulus rather than from a check inside the block.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_GRANT   = 3'd1,
    ST_RD_PC   = 3'd2,
    ST_RD_SW   = 3'd3,
    ST_PUSH_SW = 3'd4,
    ST_PUSH_PC = 3'd5,
    ST_LOAD    = 3'd6,
    ST_FAULT   = 3'd7
  } seq_state_t;

endpackage

// File: rtl/irq_vec_check.sv
module irq_vec_check #(
  parameter int unsigned AW        = 16,
  parameter int unsigned VEC_LIMIT = 16'h0100
) (
  input  logic [AW-1:0] addr,
  output logic          ok
);
  localparam logic [AW-1:0] LIMIT = AW'(VEC_LIMIT);

  logic aligned;
  logic in_window;

  always_comb begin
    aligned   = ~addr[0];
    in_window = (addr < LIMIT);
    ok        = aligned & in_window;
  end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_req,
  input  logic       vec_valid,
  input  logic       vec_ok,
  output seq_state_t state
);
  seq_state_t state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:    if (dev_req) state_d = ST_GRANT;
      ST_GRANT:   if (vec_valid) state_d = vec_ok ? ST_RD_PC : ST_FAULT;
      ST_RD_PC:   state_d = ST_RD_SW;
      ST_RD_SW:   state_d = ST_PUSH_SW;
      ST_PUSH_SW: state_d = ST_PUSH_PC;
      ST_PUSH_PC: state_d = ST_LOAD;
      ST_LOAD:    state_d = ST_IDLE;
      ST_FAULT:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/irq_mem_port.sv
module irq_mem_port
  import irq_entry_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  seq_state_t    state,
  input  logic [AW-1:0] vec_addr,
  input  logic [AW-1:0] saved_sp,
  input  logic [DW-1:0] saved_pc,
  input  logic [DW-1:0] saved_sw,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam logic [AW-1:0] STEP  = AW'(DW / 8);
  localparam logic [AW-1:0] STEP2 = AW'(2 * (DW / 8));

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_RD_PC: begin
        mem_req  = 1'b1;
        mem_addr = vec_addr;
      end
      ST_RD_SW: begin
        mem_req  = 1'b1;
        mem_addr = vec_addr + STEP;
      end
      ST_PUSH_SW: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = saved_sp - STEP;
        mem_wdata = saved_sw;
      end
      ST_PUSH_PC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = saved_sp - STEP2;
        mem_wdata = saved_pc;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 16,
  parameter int unsigned VEC_LIMIT = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_req,
  output logic          dev_grant,
  input  logic          dev_vec_valid,
  input  logic [AW-1:0] dev_vec_addr,
  input  logic [DW-1:0] core_pc,
  input  logic [DW-1:0] core_sw,
  input  logic [AW-1:0] core_sp,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          core_load,
  output logic [DW-1:0] new_pc,
  output logic [DW-1:0] new_sw,
  output logic [AW-1:0] new_sp,
  output logic          done,
  output logic          vec_err
);
  localparam logic [AW-1:0] FRAME = AW'(2 * (DW / 8));

  // reset synchroniser: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_t state;
  logic       vec_ok;

  irq_vec_check #(.AW(AW), .VEC_LIMIT(VEC_LIMIT)) u_vchk (
    .addr (dev_vec_addr),
    .ok   (vec_ok)
  );

  irq_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .dev_req   (dev_req),
    .vec_valid (dev_vec_valid),
    .vec_ok    (vec_ok),
    .state     (state)
  );

  // clock enables for the capture registers
  logic cap_en;
  logic pc_en;
  logic sw_en;

  always_comb begin
    cap_en = (state == ST_GRANT) && dev_vec_valid;
    pc_en  = (state == ST_RD_SW);
    sw_en  = (state == ST_PUSH_SW);
  end

  logic [AW-1:0] vec_q;
  logic [AW-1:0] sp_q;
  logic [DW-1:0] old_pc_q;
  logic [DW-1:0] old_sw_q;
  logic [DW-1:0] hnd_pc_q;
  logic [DW-1:0] hnd_sw_q;

  always_ff @(posedge clk) begin
    if (cap_en) begin
      vec_q    <= dev_vec_addr;
      sp_q     <= core_sp;
      old_pc_q <= core_pc;
      old_sw_q <= core_sw;
    end
  end

  always_ff @(posedge clk) begin
    if (pc_en) hnd_pc_q <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (sw_en) hnd_sw_q <= mem_rdata;
  end

  irq_mem_port #(.AW(AW), .DW(DW)) u_mem (
    .state     (state),
    .vec_addr  (vec_q),
    .saved_sp  (sp_q),
    .saved_pc  (old_pc_q),
    .saved_sw  (old_sw_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  always_comb begin
    dev_grant = (state == ST_GRANT);
    core_load = (state == ST_LOAD);
    vec_err   = (state == ST_FAULT);
    done      = core_load | vec_err;
    new_pc    = hnd_pc_q;
    new_sw    = hnd_sw_q;
    new_sp    = sp_q - FRAME;
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int unsigned AW        = 16,
  parameter int unsigned VEC_LIMIT = 16'h0100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dev_grant,
  input logic          dev_vec_valid,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          core_load,
  input logic          done,
  input logic          vec_err
);
  localparam logic [AW-1:0] LIMIT = AW'(VEC_LIMIT);

  // R2
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_grant && !dev_vec_valid |=> dev_grant);

  // R3
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_grant && dev_vec_valid |=> !dev_grant);

  // R4
  read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> (mem_addr < LIMIT) && !mem_addr[0]);

  // R4
  read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> !mem_we);

  // R5
  write_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |=> (mem_req && mem_we) || core_load);

  // R6
  load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_load |-> done && !vec_err);

  // R6
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_load |=> !core_load && !done);

  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_err |-> done && !core_load && !mem_req);

  // R9
  busy_nogrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !dev_grant);

  // R9
  done_nogrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !dev_grant);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.AW(AW), .VEC_LIMIT(VEC_LIMIT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dev_grant     (dev_grant),
  .dev_vec_valid (dev_vec_valid),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .core_load     (core_load),
  .done          (done),
  .vec_err       (vec_err)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  logic        clk;
  logic        rst_n;
  logic        dev_req;
  logic        dev_grant;
  logic        dev_vec_valid;
  logic [15:0] dev_vec_addr;
  logic [15:0] core_pc;
  logic [15:0] core_sw;
  logic [15:0] core_sp;
  logic        mem_req;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        core_load;
  logic [15:0] new_pc;
  logic [15:0] new_sw;
  logic [15:0] new_sp;
  logic        done;
  logic        vec_err;

  irq_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_grant(dev_grant),
    .dev_vec_valid(dev_vec_valid), .dev_vec_addr(dev_vec_addr),
    .core_pc(core_pc), .core_sw(core_sw), .core_sp(core_sp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .core_load(core_load),
    .new_pc(new_pc), .new_sw(new_sw), .new_sp(new_sp), .done(done),
    .vec_err(vec_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit ended = 0;

  // word memory model: one-cycle read latency
  logic [15:0] mem [0:255];
  logic        mon_clr;
  int          rd_n;
  int          wr_n;
  logic [15:0] rd_a [0:3];
  logic [15:0] wr_a [0:3];

  function automatic logic [15:0] fill_word(input logic [15:0] a);
    return {a[7:0], ~a[7:0]} ^ 16'h1234;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = fill_word(16'(i * 2));
  end

  always @(posedge clk) begin
    if (mon_clr) begin
      rd_n <= 0;
      wr_n <= 0;
    end else if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[8:1]] <= mem_wdata;
        if (wr_n < 4) wr_a[wr_n] <= mem_addr;
        wr_n <= wr_n + 1;
      end else begin
        mem_rdata <= mem[mem_addr[8:1]];
        if (rd_n < 4) rd_a[rd_n] <= mem_addr;
        rd_n <= rd_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    dev_req = 1'b1;
    dev_vec_valid = 1'b0;
    dev_vec_addr = '0;
    core_pc = '0; core_sw = '0; core_sp = 16'h01F0;
    mon_clr = 1'b1;
    repeat (3) @(negedge clk);
    chk(!dev_grant && !mem_req && !mem_we, "R1 grant/mem in reset", {dev_grant, mem_req, mem_we}, 0);
    chk(!core_load && !done && !vec_err, "R1 load/done/err in reset", {core_load, done, vec_err}, 0);
    dev_req = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_clr = 1'b0;
    chk(!dev_grant && !done, "R1 idle after release", {dev_grant, done}, 0);
  endtask

  // raise request, wait one granted cycle, then supply vector
  task automatic front(input logic [15:0] vec, input logic [15:0] pc,
                       input logic [15:0] sw, input logic [15:0] sp);
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    core_pc = pc; core_sw = sw; core_sp = sp;
    dev_req = 1'b1;
    @(negedge clk);
    chk(dev_grant, "R2 grant after request", dev_grant, 1);
    @(negedge clk);
    chk(dev_grant, "R2 grant held without vector", dev_grant, 1);
    dev_vec_valid = 1'b1;
    dev_vec_addr = vec;
    @(negedge clk);
    dev_vec_valid = 1'b0;
    dev_vec_addr = 16'hFFFF;
    dev_req = 1'b0;
    core_pc = ~pc; core_sw = ~sw; core_sp = 16'h0000;
    chk(!dev_grant, "R3 grant dropped after vector", dev_grant, 0);
  endtask

  task automatic t_entry(input logic [15:0] vec, input logic [15:0] pc,
                         input logic [15:0] sw, input logic [15:0] sp);
    int n = 0;
    front(vec, pc, sw, sp);
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == 4, "R6 load latency", n, 4);
    chk(core_load && !vec_err, "R6 load with done", {core_load, vec_err}, 2);
    chk(new_pc == fill_word(vec), "R6 new pc", new_pc, fill_word(vec));
    chk(new_sw == fill_word(vec + 16'd2), "R6 new sw", new_sw, fill_word(vec + 16'd2));
    chk(new_sp == sp - 16'd4, "R6 new sp", new_sp, sp - 16'd4);
    @(negedge clk);
    chk(!core_load && !done, "R6 single-cycle load", {core_load, done}, 0);
    chk(rd_n == 2, "R4 read count", rd_n, 2);
    chk(rd_a[0] == vec && rd_a[1] == vec + 16'd2, "R4 read order", rd_a[1], vec + 16'd2);
    chk(wr_n == 2, "R5 write count", wr_n, 2);
    chk(wr_a[0] == sp - 16'd2 && wr_a[1] == sp - 16'd4, "R5 write order", wr_a[1], sp - 16'd4);
    chk(mem[8'((sp - 16'd2) >> 1)] == sw, "R5 saved sw", mem[8'((sp - 16'd2) >> 1)], sw);
    chk(mem[8'((sp - 16'd4) >> 1)] == pc, "R5 saved pc (R3 capture)", mem[8'((sp - 16'd4) >> 1)], pc);
  endtask

  task automatic t_fault(input logic [15:0] vec, input string tag);
    front(vec, 16'hAAAA, 16'h5555, 16'h01E0);
    chk(done && vec_err && !core_load, {tag, " error pulse"}, {done, vec_err, core_load}, 6);
    @(negedge clk);
    chk(!done && !vec_err, {tag, " error is one cycle"}, {done, vec_err}, 0);
    chk(rd_n + wr_n == 0, {tag, " no memory access"}, rd_n + wr_n, 0);
  endtask

  task automatic t_busy();
    int n = 0;
    int g = 0;
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    core_pc = 16'h4321; core_sw = 16'h00E0; core_sp = 16'h01C0;
    dev_req = 1'b1;
    @(negedge clk);
    dev_vec_valid = 1'b1;
    dev_vec_addr = 16'h0040;
    @(negedge clk);
    dev_vec_valid = 1'b0;
    while (!done && n < 20) begin
      if (dev_grant) g++;
      @(negedge clk);
      n++;
    end
    chk(g == 0, "R9 no grant while busy", g, 0);
    @(negedge clk);
    chk(!dev_grant, "R9 idle cycle after done", dev_grant, 0);
    @(negedge clk);
    chk(dev_grant, "R9 held request granted", dev_grant, 1);
    dev_vec_valid = 1'b1;
    dev_vec_addr = 16'h0003;
    @(negedge clk);
    dev_vec_valid = 1'b0;
    dev_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_entry(16'h0010, 16'h1000, 16'h00C3, 16'h01F0);
    t_entry(16'h0000, 16'hBEEF, 16'h8001, 16'h0180);
    t_entry(16'h00FC, 16'h7FFE, 16'hFFFF, 16'h01FE);
    t_fault(16'h0100, "R7 vector at limit");
    t_fault(16'h8000, "R7 vector high");
    t_fault(16'h0021, "R8 odd vector");
    t_fault(16'h0101, "R8 odd and high");
    t_busy();
    t_entry(16'h0080, 16'h0246, 16'h1357, 16'h01A0);
    finish_run();
  end
endmodule